// File: doc/BRIEF.md
# Read-Reuse Bypass Predictor

This block decides, for each line the cache is about to allocate, whether the line should be kept or sent straight past the cache. The decision comes from an untagged table of 2-bit saturating counters. The table is indexed by the hashed program counter of the instruction that asks for the allocation. A counter at zero means that lines brought in by that instruction are not expected to be read again, so the line bypasses the cache. Any other value means the line is allocated.

The table learns from a small group of sampled cache sets. Each sampled set keeps a shadow directory of tags kept in LRU order. A shadow entry holds a partial tag, the index bits of the allocating instruction's hashed PC, a valid bit, a rank and a critical bit. The critical bit starts cleared. Only a later read to the line sets it, because reuse by writes does not count. When a shadow entry is pushed out, its stored PC selects a counter. That counter moves up if the entry was read again and down if it was not. The shadow directories model a cache that never bypasses, so every sampled miss allocates a shadow entry.

The cache controller drives one access per cycle. With the access it gives the type, the tag, whether the set is sampled (and which sampled set it is) and whether the access needs an allocation decision.

Top module: `read_reuse_bypass`

## Requirements
- R1: After reset `bypass_vld` is 0 and every counter holds 1, so the first lookup of any PC returns allocate (`bypass` = 0). Asserting `rst_n` at any time clears `bypass_vld` at once and restores this state.
- R2: A lookup (`acc_valid` and `acc_alloc` both 1) in cycle N gives `bypass_vld` = 1 with the decision in cycle N+1. In any cycle after a cycle without a lookup, `bypass_vld` and `bypass` are 0.
- R3: `bypass` is 1 exactly when the counter selected by `acc_pc` held 0 at the lookup. A counter value of 1, 2 or 3 gives 0.
- R4: Pushing out a valid shadow entry whose critical bit is 0 decrements the counter selected by its stored PC. The counter stops at 0.
- R5: Pushing out a valid shadow entry whose critical bit is 1 increments that counter. The counter stops at 3.
- R6: A shadow entry is created with its critical bit cleared, whether the missing access is a read (`acc_write` = 0) or a write (`acc_write` = 1). A write that hits the entry leaves the critical bit unchanged.
- R7: A read that hits a shadow entry sets its critical bit.
- R8: In a sampled set, a miss places the new entry at the most recently used rank. Once all WAYS entries are valid, a miss pushes out the least recently used entry. A hit of either type moves the entry to the most recently used rank. No training happens while a set still has invalid entries.
- R9: A hit does not change the PC stored in the entry. Training always uses the PC of the access that created the entry.
- R10: When a push-out updates a counter in the same cycle as a lookup of that counter, the lookup returns the decision from the value before the update. A lookup in the next cycle sees the updated value.
- R11: An access with `acc_sampled` = 0 changes no shadow directory and trains no counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | Access type: 1 write, 0 read |
| acc_sampled | input | 1 | The access falls in a sampled set |
| acc_alloc | input | 1 | The cache is allocating for this access and needs a decision |
| acc_set | input | $clog2(SAMPLE_SETS) | Which sampled set the access maps to |
| acc_tag | input | TAG_W | Partial address tag |
| acc_pc | input | IDX_W | Index bits of the hashed PC of the accessing instruction |
| bypass_vld | output | 1 | A decision is present this cycle |
| bypass | output | 1 | 1: send the line past the cache; 0: allocate |

## Verification
The decision for a lookup is registered, so it appears one cycle after the lookup. The bench drives each access on a falling edge and reads `bypass_vld` and `bypass` on the next falling edge, which comes after exactly one rising edge. A shadow push-out trains its counter at the rising edge that ends the access cycle. The bench therefore expects the change from a lookup issued in the following cycle, and it checks that a lookup in the same cycle as the push-out still sees the old value. The shadow sets are driven with fill-in-order sequences of unique tags, so each push-out happens a known number of misses after its entry was created. With this, the bench can work out every counter value by hand, including saturation at both ends.

// File: rtl/rrbp_pkg.sv
package rrbp_pkg;

  // Width of one predictor counter and its reset value.
  localparam int CTR_W = 2;
  localparam logic [CTR_W-1:0] CTR_TOP  = '1;
  localparam logic [CTR_W-1:0] CTR_BOT  = '0;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(1);

  // One saturating step: up when the pushed-out line saw read reuse.
  function automatic logic [CTR_W-1:0] ctr_step(input logic [CTR_W-1:0] cur,
                                                input logic              up);
    logic [CTR_W-1:0] res;
    if (up) res = (cur == CTR_TOP) ? cur : cur + CTR_W'(1);
    else    res = (cur == CTR_BOT) ? cur : cur - CTR_W'(1);
    return res;
  endfunction

endpackage

// File: rtl/rrbp_shadow.sv
module rrbp_shadow #(
  parameter  int SETS  = 32,
  parameter  int WAYS  = 16,
  parameter  int TAG_W = 15,
  parameter  int IDX_W = 12,
  localparam int SET_W = $clog2(SETS),
  localparam int AGE_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_sampled,
  input  logic [SET_W-1:0] acc_set,
  input  logic [TAG_W-1:0] acc_tag,
  input  logic [IDX_W-1:0] acc_pc,
  output logic             train_en,
  output logic [IDX_W-1:0] train_idx,
  output logic             train_inc
);

  // Shadow storage: rank 0 is most recent, rank WAYS-1 is least recent.
  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [IDX_W-1:0] pc_q   [SETS][WAYS];
  logic [AGE_W-1:0] age_q  [SETS][WAYS];
  logic [WAYS-1:0]  crit_q [SETS];
  logic [WAYS-1:0]  vld_q  [SETS];

  // Next state of the addressed set.
  logic [TAG_W-1:0] tag_n [WAYS];
  logic [IDX_W-1:0] pc_n  [WAYS];
  logic [AGE_W-1:0] age_n [WAYS];
  logic [WAYS-1:0]  crit_n;
  logic [WAYS-1:0]  vld_n;

  logic [WAYS-1:0]  hit_vec;
  logic [WAYS-1:0]  old_vec;
  logic             upd;
  logic             hit;
  logic [AGE_W-1:0] hit_age;
  logic [IDX_W-1:0] old_pc;
  logic             old_crit;
  logic             old_vld;

  // Match and oldest-way detection, one per way.
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w] = vld_q[acc_set][w] && (tag_q[acc_set][w] == acc_tag);
    assign old_vec[w] = (age_q[acc_set][w] == AGE_W'(WAYS-1));
  end

  always_comb begin
    upd      = acc_valid & acc_sampled;
    hit      = |hit_vec;
    hit_age  = '0;
    old_pc   = '0;
    old_crit = 1'b0;
    old_vld  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_age = hit_age | age_q[acc_set][w];
      if (old_vec[w]) begin
        old_pc   = old_pc | pc_q[acc_set][w];
        old_crit = old_crit | crit_q[acc_set][w];
        old_vld  = old_vld | vld_q[acc_set][w];
      end
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      tag_n[w]  = tag_q[acc_set][w];
      pc_n[w]   = pc_q[acc_set][w];
      age_n[w]  = age_q[acc_set][w];
      crit_n[w] = crit_q[acc_set][w];
      vld_n[w]  = vld_q[acc_set][w];
      if (hit) begin
        if (hit_vec[w]) begin
          age_n[w]  = '0;
          crit_n[w] = crit_q[acc_set][w] | ~acc_write;
        end else if (age_q[acc_set][w] < hit_age) begin
          age_n[w]  = age_q[acc_set][w] + AGE_W'(1);
        end
      end else if (old_vec[w]) begin
        age_n[w]  = '0;
        tag_n[w]  = acc_tag;
        pc_n[w]   = acc_pc;
        crit_n[w] = 1'b0;
        vld_n[w]  = 1'b1;
      end else begin
        age_n[w]  = age_q[acc_set][w] + AGE_W'(1);
      end
    end
  end

  assign train_en  = upd & ~hit & old_vld;
  assign train_idx = old_pc;
  assign train_inc = old_crit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        crit_q[s] <= '0;
        vld_q[s]  <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          pc_q[s][w]  <= '0;
          age_q[s][w] <= AGE_W'(w);
        end
      end
    end else if (upd) begin
      crit_q[acc_set] <= crit_n;
      vld_q[acc_set]  <= vld_n;
      for (int w = 0; w < WAYS; w++) begin
        tag_q[acc_set][w] <= tag_n[w];
        pc_q[acc_set][w]  <= pc_n[w];
        age_q[acc_set][w] <= age_n[w];
      end
    end
  end

endmodule

// File: rtl/rrbp_table.sv
module rrbp_table
  import rrbp_pkg::*;
#(
  parameter  int IDX_W   = 12,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             train_en,
  input  logic [IDX_W-1:0] train_idx,
  input  logic             train_inc,
  input  logic             lk_en,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             dec_vld,
  output logic             dec_byp
);

  logic [CTR_W-1:0] ctr_q [ENTRIES];
  logic [CTR_W-1:0] ctr_n;
  logic [CTR_W-1:0] lk_ctr;
  logic             byp_n;

  always_comb begin
    ctr_n  = ctr_step(ctr_q[train_idx], train_inc);
    lk_ctr = ctr_q[lk_idx];
    byp_n  = lk_en && (lk_ctr == CTR_BOT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_INIT;
    end else if (train_en) begin
      ctr_q[train_idx] <= ctr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld <= 1'b0;
      dec_byp <= 1'b0;
    end else begin
      dec_vld <= lk_en;
      dec_byp <= byp_n;
    end
  end

endmodule

// File: rtl/read_reuse_bypass.sv
module read_reuse_bypass #(
  parameter  int TAG_W       = 15,
  parameter  int SAMPLE_SETS = 32,
  parameter  int WAYS        = 16,
  parameter  int IDX_W       = 12,
  localparam int SET_W       = $clog2(SAMPLE_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_sampled,
  input  logic             acc_alloc,
  input  logic [SET_W-1:0] acc_set,
  input  logic [TAG_W-1:0] acc_tag,
  input  logic [IDX_W-1:0] acc_pc,
  output logic             bypass_vld,
  output logic             bypass
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic [1:0] rst_pipe_n;
  logic       rst_int_n;

  always_comb rst_pipe_n = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_n;
  end

  assign rst_int_n = rst_pipe_q[1];

  logic             train_en;
  logic [IDX_W-1:0] train_idx;
  logic             train_inc;
  logic             lk_en;

  assign lk_en = acc_valid & acc_alloc;

  rrbp_shadow #(
    .SETS (SAMPLE_SETS),
    .WAYS (WAYS),
    .TAG_W(TAG_W),
    .IDX_W(IDX_W)
  ) u_shadow (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_sampled(acc_sampled),
    .acc_set    (acc_set),
    .acc_tag    (acc_tag),
    .acc_pc     (acc_pc),
    .train_en   (train_en),
    .train_idx  (train_idx),
    .train_inc  (train_inc)
  );

  rrbp_table #(
    .IDX_W(IDX_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .train_en (train_en),
    .train_idx(train_idx),
    .train_inc(train_inc),
    .lk_en    (lk_en),
    .lk_idx   (acc_pc),
    .dec_vld  (bypass_vld),
    .dec_byp  (bypass)
  );

endmodule

// File: rtl/rrbp_chk.sv
module rrbp_chk (
  input logic clk,
  input logic rst_n,
  input logic acc_valid,
  input logic acc_alloc,
  input logic acc_sampled,
  input logic bypass_vld,
  input logic bypass,
  input logic train_en
);

  // R2
  lookup_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_alloc) |=> bypass_vld);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_alloc) |=> (!bypass_vld && !bypass));

  // R3
  bypass_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> bypass_vld);

  // R11
  unsampled_no_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_sampled) |-> !train_en);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> !bypass_vld);

endmodule

bind read_reuse_bypass rrbp_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .acc_valid  (acc_valid),
  .acc_alloc  (acc_alloc),
  .acc_sampled(acc_sampled),
  .bypass_vld (bypass_vld),
  .bypass     (bypass),
  .train_en   (train_en)
);

// File: tb/tb_read_reuse_bypass.sv
`timescale 1ns/100ps
module tb_read_reuse_bypass;

  localparam int TAG_W = 15;
  localparam int SETS  = 4;
  localparam int WAYS  = 4;
  localparam int IDX_W = 6;
  localparam int SET_W = $clog2(SETS);

  // PC indexes used by the scenarios.
  localparam logic [IDX_W-1:0] P = 6'h11; // trained PC
  localparam logic [IDX_W-1:0] Q = 6'h25; // PC carried by hits only
  localparam logic [IDX_W-1:0] F = 6'h30; // filler PC
  localparam logic [IDX_W-1:0] H = 6'h05; // PC for the ordering test

  typedef struct packed {
    logic             smp;
    logic             wr;
    logic [SET_W-1:0] set;
    logic [TAG_W-1:0] tag;
    logic [IDX_W-1:0] pc;
    logic             alloc;
    logic             exp;
    logic [3:0]       req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    // set 0: three entries of P, each read again (R7, R9 via PC Q on hits)
    '{1'b1,1'b0,2'd0,15'h100,P,1'b0,1'b0,4'd7},
    '{1'b1,1'b0,2'd0,15'h100,Q,1'b0,1'b0,4'd7},
    '{1'b1,1'b0,2'd0,15'h101,P,1'b0,1'b0,4'd7},
    '{1'b1,1'b0,2'd0,15'h101,Q,1'b0,1'b0,4'd7},
    '{1'b1,1'b0,2'd0,15'h102,P,1'b0,1'b0,4'd7},
    '{1'b1,1'b0,2'd0,15'h102,Q,1'b0,1'b0,4'd7},
    // write-allocated entries, one with a write hit (R6)
    '{1'b1,1'b1,2'd0,15'h103,P,1'b0,1'b0,4'd6},
    '{1'b1,1'b1,2'd0,15'h103,P,1'b0,1'b0,4'd6},
    // push-outs of the three read-again entries: 1->2->3->3 (R5)
    '{1'b1,1'b1,2'd0,15'h104,P,1'b0,1'b0,4'd5},
    '{1'b1,1'b1,2'd0,15'h105,P,1'b0,1'b0,4'd5},
    '{1'b1,1'b1,2'd0,15'h106,P,1'b0,1'b0,4'd5},
    '{1'b0,1'b0,2'd0,15'h200,P,1'b1,1'b0,4'd5},   // R5 counter 3, allocate
    '{1'b0,1'b1,2'd0,15'h300,F,1'b0,1'b0,4'd11},  // R11 unsampled miss
    '{1'b1,1'b1,2'd0,15'h107,P,1'b0,1'b0,4'd4},   // R4 3->2
    '{1'b1,1'b0,2'd0,15'h107,Q,1'b0,1'b0,4'd7},   // read hit makes it critical
    '{1'b1,1'b1,2'd0,15'h108,F,1'b0,1'b0,4'd4},   // R4 2->1
    '{1'b0,1'b0,2'd0,15'h200,P,1'b1,1'b0,4'd11},  // R11 counter 1, allocate
    '{1'b1,1'b1,2'd0,15'h109,P,1'b1,1'b0,4'd10},  // R10 1->0, same cycle old value
    '{1'b0,1'b0,2'd0,15'h200,P,1'b1,1'b1,4'd4},   // R4 R3 counter 0, bypass
    '{1'b1,1'b1,2'd0,15'h10A,F,1'b0,1'b0,4'd4},   // R4 floor
    '{1'b0,1'b0,2'd0,15'h200,P,1'b1,1'b1,4'd4},   // R4 still 0
    '{1'b1,1'b1,2'd0,15'h10B,F,1'b0,1'b0,4'd5},   // R5 0->1
    '{1'b0,1'b0,2'd0,15'h200,P,1'b1,1'b0,4'd9},   // R9 counter 1, allocate
    // set 1: ordering (R8) with a read-allocated, write-hit entry (R6)
    '{1'b1,1'b0,2'd1,15'h200,H,1'b0,1'b0,4'd6},
    '{1'b1,1'b1,2'd1,15'h201,F,1'b0,1'b0,4'd8},
    '{1'b1,1'b1,2'd1,15'h202,F,1'b0,1'b0,4'd8},
    '{1'b1,1'b1,2'd1,15'h203,F,1'b0,1'b0,4'd8},
    '{1'b1,1'b1,2'd1,15'h200,F,1'b0,1'b0,4'd8},   // write hit -> most recent
    '{1'b1,1'b1,2'd1,15'h204,F,1'b0,1'b0,4'd8},
    '{1'b1,1'b1,2'd1,15'h205,F,1'b0,1'b0,4'd8},
    '{1'b1,1'b1,2'd1,15'h206,F,1'b0,1'b0,4'd8},
    '{1'b0,1'b0,2'd1,15'h000,H,1'b1,1'b0,4'd8},   // R8 H not yet pushed out
    '{1'b1,1'b1,2'd1,15'h207,F,1'b0,1'b0,4'd6},   // pushes out H entry, 1->0
    '{1'b0,1'b0,2'd1,15'h000,H,1'b1,1'b1,4'd6}    // R6 non-critical, bypass
  };

  logic             clk;
  logic             rst_n;
  logic             acc_valid;
  logic             acc_write;
  logic             acc_sampled;
  logic             acc_alloc;
  logic [SET_W-1:0] acc_set;
  logic [TAG_W-1:0] acc_tag;
  logic [IDX_W-1:0] acc_pc;
  logic             bypass_vld;
  logic             bypass;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  read_reuse_bypass #(
    .TAG_W      (TAG_W),
    .SAMPLE_SETS(SETS),
    .WAYS       (WAYS),
    .IDX_W      (IDX_W)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_sampled(acc_sampled),
    .acc_alloc  (acc_alloc),
    .acc_set    (acc_set),
    .acc_tag    (acc_tag),
    .acc_pc     (acc_pc),
    .bypass_vld (bypass_vld),
    .bypass     (bypass)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    acc_valid   = 1'b0;
    acc_write   = 1'b0;
    acc_sampled = 1'b0;
    acc_alloc   = 1'b0;
    acc_set     = '0;
    acc_tag     = '0;
    acc_pc      = '0;
  endtask

  // Called at a falling edge; checks the decision one falling edge later.
  task automatic lookup(input logic [IDX_W-1:0] pc, input logic exp, input string tag);
    acc_valid   = 1'b1;
    acc_alloc   = 1'b1;
    acc_sampled = 1'b0;
    acc_pc      = pc;
    @(negedge clk);
    check(tag, "decision valid", bypass_vld, 1'b1);
    check(tag, "bypass", bypass, exp);
    idle();
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", bypass_vld, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "valid after reset", bypass_vld, 1'b0);
    check("R1", "bypass after reset", bypass, 1'b0);

    // R1: untouched counters allocate
    lookup(6'h00, 1'b0, "R1");
    lookup(H,     1'b0, "R1");
    lookup(6'h3F, 1'b0, "R1");
    lookup(P,     1'b0, "R1");
    @(negedge clk);
    check("R2", "valid without lookup", bypass_vld, 1'b0);

    // Vector walk: each row driven on a falling edge, answered on the next.
    for (int i = 0; i < NV; i++) begin
      acc_valid   = 1'b1;
      acc_sampled = VEC[i].smp;
      acc_write   = VEC[i].wr;
      acc_set     = VEC[i].set;
      acc_tag     = VEC[i].tag;
      acc_pc      = VEC[i].pc;
      acc_alloc   = VEC[i].alloc;
      @(negedge clk);
      check("R2", $sformatf("row %0d valid", i), bypass_vld, VEC[i].alloc);
      if (VEC[i].alloc)
        check($sformatf("R%0d", VEC[i].req), $sformatf("row %0d bypass", i),
              bypass, VEC[i].exp);
    end
    idle();
    @(negedge clk);

    // R1: reset in mid-run clears the valid at once and the counters
    rst_n = 1'b0;
    #1;
    check("R1", "valid during reset", bypass_vld, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    lookup(H, 1'b0, "R1");
    lookup(P, 1'b0, "R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule